// File: doc/BRIEF.md
# Thread-Identifier System Register with Fine-Grained Access Trapping

This block holds one software-owned thread-identifier word inside a processor's system-register space and decides, in the cycle the access is presented, whether that access completes or is diverted to the hypervisor level. A request carries the five-field register encoding, a direction flag and the current exception level. When the encoding selects this register, the request is either completed or trapped. A completed read returns the stored word on the read port. A completed write captures the write data at the next clock edge. A trapped access produces a trap flag, the target level and an exception-class code. The hardware never interprets the stored value.

Two controls decide whether an access traps: a read-trap bit and a separate write-trap bit. Each takes effect only when all of these hold: the hypervisor level is enabled, the fine-grained trap feature is present, and the monitor level either is absent or has enabled the feature. At the lowest level, host mode also exempts the access. A 32-bit alias view shares the low half of the storage. A surrounding decoder uses the `hit` output to flag encodings that select nothing.

Top module: `tid_access_unit`

## Requirements
- R1: A write that selects the register and does not trap stores all 64 bits of `wrData` at the clock edge. A later non-trapped read returns that value on `rdData` with `rdValid` high, in the same cycle as the request.
- R2: `hit` is high only when `reqValid` is high and the encoding is exactly op0=2'b11, op1=3'b011, CRn=4'b1101, CRm=4'b0000, op2=3'b010. An access without a hit never traps, never raises `rdValid`, and never changes the stored value.
- R3: At level 0 (`curEl`=0), an access traps only when all of these hold: `hypEnabled`=1, `el0InHost`=0, `fgtPresent`=1, (`el3Present`=0 or `monFgtEnable`=1), and the trap bit for the access direction is 1.
- R4: At level 1 (`curEl`=1), the trap test is the R3 test without the host-mode term. `el0InHost` has no effect at this level.
- R5: At levels 2 and 3 (`curEl`=2 or 3), reads and writes always complete and never trap, whatever the values of the trap controls.
- R6: Reads are gated only by `rdTrapBit` and writes only by `wrTrapBit`. The trap bit of the other direction has no effect.
- R7: While `trap` is high, `trapTargetEl` is 2 and `trapClass` is 6'h18. While `trap` is low, both are zero.
- R8: A trapped write leaves the stored value unchanged. A trapped read keeps `rdValid` low and `rdData` at zero.
- R9: `aliasRdData` always equals bits [31:0] of the stored value. When `aliasWrEn` is high, bits [31:0] take `aliasWrData` at the clock edge and bits [63:32] are unchanged.
- R10: When a completed 64-bit write and an alias write happen in the same cycle, the 64-bit write takes effect and the alias write is dropped.
- R11: While `rstN` is low, no access has any effect and all request outputs are idle. With `CLEAR_ON_RESET`=1, reset clears the stored value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOp0 | input | 2 | Encoding field op0 |
| reqOp1 | input | 3 | Encoding field op1 |
| reqCrn | input | 4 | Encoding field CRn |
| reqCrm | input | 4 | Encoding field CRm |
| reqOp2 | input | 3 | Encoding field op2 |
| curEl | input | 2 | Current exception level 0..3 |
| hypEnabled | input | 1 | Hypervisor level enabled |
| el0InHost | input | 1 | Level 0 running in host mode |
| fgtPresent | input | 1 | Fine-grained trap feature implemented |
| el3Present | input | 1 | Monitor level implemented |
| monFgtEnable | input | 1 | Monitor's enable for fine-grained traps |
| rdTrapBit | input | 1 | Read-trap control for this register |
| wrTrapBit | input | 1 | Write-trap control for this register |
| wrData | input | 64 | Write data from general register |
| rdData | output | 64 | Read data, zero unless rdValid |
| rdValid | output | 1 | Completed read this cycle |
| hit | output | 1 | Request selects this register |
| trap | output | 1 | Access diverted to hypervisor level |
| trapTargetEl | output | 2 | Trap target level (2) |
| trapClass | output | 6 | Exception class code (0x18) |
| aliasWrEn | input | 1 | 32-bit alias write strobe |
| aliasWrData | input | 32 | 32-bit alias write data |
| aliasRdData | output | 32 | 32-bit alias read view |

## Verification
The bench uses the default parameters: a 64-bit register, a 32-bit alias and `CLEAR_ON_RESET`=1. With these settings the reset value is a known zero, so reads can be checked from the first cycle after reset and after a reset in mid-run. The 32-bit split lets the bench check that alias writes leave the upper half alone and check the ordering when an alias write meets a 64-bit write in the same cycle. The default encoding constants make each of the five fields testable one at a time for a miss.

// File: rtl/tid_access_pkg.sv
package tid_access_pkg;
  typedef struct packed {
    logic wrFull;   // completed 64-bit write
    logic wrAlias;  // alias low-half write
    logic rdEn;     // completed read
  } tidStrobe_t;

  localparam logic [1:0] EL_USER  = 2'd0;
  localparam logic [1:0] EL_KERN  = 2'd1;
  localparam logic [1:0] EL_HYP   = 2'd2;
endpackage

// File: rtl/tid_access_ctrl.sv
module tid_access_ctrl
  import tid_access_pkg::*;
#(
  parameter logic [1:0] SEL_OP0 = 2'b11,
  parameter logic [2:0] SEL_OP1 = 3'b011,
  parameter logic [3:0] SEL_CRN = 4'b1101,
  parameter logic [3:0] SEL_CRM = 4'b0000,
  parameter logic [2:0] SEL_OP2 = 3'b010
) (
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqOp0,
  input  logic [2:0] reqOp1,
  input  logic [3:0] reqCrn,
  input  logic [3:0] reqCrm,
  input  logic [2:0] reqOp2,
  input  logic [1:0] curEl,
  input  logic       hypEnabled,
  input  logic       el0InHost,
  input  logic       fgtPresent,
  input  logic       el3Present,
  input  logic       monFgtEnable,
  input  logic       rdTrapBit,
  input  logic       wrTrapBit,
  input  logic       aliasWrEn,
  output logic       hit,
  output logic       trap,
  output tidStrobe_t stb
);
  logic liveReq;
  logic encMatch;
  logic fgtArmed;
  logic dirBit;
  logic trapCond;

  assign liveReq  = reqValid & rstN;
  assign encMatch = (reqOp0 == SEL_OP0) && (reqOp1 == SEL_OP1) &&
                    (reqCrn == SEL_CRN) && (reqCrm == SEL_CRM) &&
                    (reqOp2 == SEL_OP2);
  assign hit      = liveReq & encMatch;

  // feature armed only if the hypervisor is on and the monitor allows it
  assign fgtArmed = hypEnabled & fgtPresent & (~el3Present | monFgtEnable);
  assign dirBit   = reqWrite ? wrTrapBit : rdTrapBit;

  always_comb begin
    unique case (curEl)
      EL_USER: trapCond = fgtArmed & ~el0InHost & dirBit;
      EL_KERN: trapCond = fgtArmed & dirBit;
      default: trapCond = 1'b0;
    endcase
  end

  assign trap = hit & trapCond;

  always_comb begin
    stb.wrFull  = hit & reqWrite & ~trapCond;
    stb.rdEn    = hit & ~reqWrite & ~trapCond;
    stb.wrAlias = rstN & aliasWrEn & ~stb.wrFull;
  end
endmodule

// File: rtl/tid_access_dp.sv
module tid_access_dp
  import tid_access_pkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int ALIAS_W        = 32,
  parameter bit CLEAR_ON_RESET = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tidStrobe_t         stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ALIAS_W-1:0] aliasWrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [ALIAS_W-1:0] aliasRdData
);
  localparam int HI_W = DATA_W - ALIAS_W;

  logic [ALIAS_W-1:0] loQ;
  logic [HI_W-1:0]    hiQ;

  generate
    if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk) begin
        if (!rstN) begin
          loQ <= '0;
          hiQ <= '0;
        end else if (stb.wrFull) begin
          loQ <= wrData[ALIAS_W-1:0];
          hiQ <= wrData[DATA_W-1:ALIAS_W];
        end else if (stb.wrAlias) begin
          loQ <= aliasWrData;
        end
      end
    end else begin : g_noclr
      always_ff @(posedge clk) begin
        if (stb.wrFull) begin
          loQ <= wrData[ALIAS_W-1:0];
          hiQ <= wrData[DATA_W-1:ALIAS_W];
        end else if (stb.wrAlias) begin
          loQ <= aliasWrData;
        end
      end
    end
  endgenerate

  assign rdData      = stb.rdEn ? {hiQ, loQ} : '0;
  assign aliasRdData = loQ;
endmodule

// File: rtl/tid_access_unit.sv
module tid_access_unit
  import tid_access_pkg::*;
#(
  parameter int          DATA_W         = 64,
  parameter int          ALIAS_W        = 32,
  parameter bit          CLEAR_ON_RESET = 1'b1,
  parameter int          EC_W           = 6,
  parameter logic [5:0]  TRAP_EC        = 6'h18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [1:0]         reqOp0,
  input  logic [2:0]         reqOp1,
  input  logic [3:0]         reqCrn,
  input  logic [3:0]         reqCrm,
  input  logic [2:0]         reqOp2,
  input  logic [1:0]         curEl,
  input  logic               hypEnabled,
  input  logic               el0InHost,
  input  logic               fgtPresent,
  input  logic               el3Present,
  input  logic               monFgtEnable,
  input  logic               rdTrapBit,
  input  logic               wrTrapBit,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  output logic               hit,
  output logic               trap,
  output logic [1:0]         trapTargetEl,
  output logic [EC_W-1:0]    trapClass,
  input  logic               aliasWrEn,
  input  logic [ALIAS_W-1:0] aliasWrData,
  output logic [ALIAS_W-1:0] aliasRdData
);
  tidStrobe_t stb;

  tid_access_ctrl u_ctrl (
    .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOp0(reqOp0), .reqOp1(reqOp1), .reqCrn(reqCrn), .reqCrm(reqCrm),
    .reqOp2(reqOp2), .curEl(curEl), .hypEnabled(hypEnabled),
    .el0InHost(el0InHost), .fgtPresent(fgtPresent), .el3Present(el3Present),
    .monFgtEnable(monFgtEnable), .rdTrapBit(rdTrapBit), .wrTrapBit(wrTrapBit),
    .aliasWrEn(aliasWrEn), .hit(hit), .trap(trap), .stb(stb)
  );

  tid_access_dp #(
    .DATA_W(DATA_W), .ALIAS_W(ALIAS_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .aliasWrData(aliasWrData), .rdData(rdData), .aliasRdData(aliasRdData)
  );

  assign rdValid      = stb.rdEn;
  assign trapTargetEl = trap ? EL_HYP : 2'd0;
  assign trapClass    = trap ? TRAP_EC[EC_W-1:0] : '0;
endmodule

// File: rtl/tid_access_checker.sv
module tid_access_checker #(
  parameter int DATA_W  = 64,
  parameter int ALIAS_W = 32,
  parameter int EC_W    = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqWrite,
  input logic [1:0]         curEl,
  input logic               hit,
  input logic               trap,
  input logic               rdValid,
  input logic [DATA_W-1:0]  rdData,
  input logic [1:0]         trapTargetEl,
  input logic [EC_W-1:0]    trapClass,
  input logic               aliasWrEn,
  input logic [ALIAS_W-1:0] aliasRdData
);
  assert_nohit_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (!trap && !rdValid));

  assert_upper_levels_free_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curEl[1] && reqValid) |-> !trap);

  assert_trap_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> (trapTargetEl == 2'd2 && trapClass == 6'h18));

  assert_trapped_read_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> (!rdValid && rdData == '0));

  assert_trapped_write_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (trap && reqWrite && !aliasWrEn) |=> (aliasRdData == $past(aliasRdData)));

  assert_reset_idle_R11: assert property (@(posedge clk)
    !rstN |-> (!hit && !trap && !rdValid));
endmodule

bind tid_access_unit tid_access_checker #(
  .DATA_W(DATA_W), .ALIAS_W(ALIAS_W), .EC_W(EC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .curEl(curEl), .hit(hit), .trap(trap), .rdValid(rdValid), .rdData(rdData),
  .trapTargetEl(trapTargetEl), .trapClass(trapClass), .aliasWrEn(aliasWrEn),
  .aliasRdData(aliasRdData)
);

// File: tb/tid_access_unit_tb.sv
module tid_access_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [1:0]  reqOp0;
  logic [2:0]  reqOp1;
  logic [3:0]  reqCrn, reqCrm;
  logic [2:0]  reqOp2;
  logic [1:0]  curEl;
  logic        hypEnabled, el0InHost, fgtPresent, el3Present, monFgtEnable;
  logic        rdTrapBit, wrTrapBit;
  logic [63:0] wrData, rdData;
  logic        rdValid, hit, trap;
  logic [1:0]  trapTargetEl;
  logic [5:0]  trapClass;
  logic        aliasWrEn;
  logic [31:0] aliasWrData, aliasRdData;

  int checks = 0;
  int errors = 0;
  logic [63:0] model = 64'h0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tid_access_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOp0(reqOp0), .reqOp1(reqOp1), .reqCrn(reqCrn), .reqCrm(reqCrm),
    .reqOp2(reqOp2), .curEl(curEl), .hypEnabled(hypEnabled),
    .el0InHost(el0InHost), .fgtPresent(fgtPresent), .el3Present(el3Present),
    .monFgtEnable(monFgtEnable), .rdTrapBit(rdTrapBit), .wrTrapBit(wrTrapBit),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .hit(hit),
    .trap(trap), .trapTargetEl(trapTargetEl), .trapClass(trapClass),
    .aliasWrEn(aliasWrEn), .aliasWrData(aliasWrData), .aliasRdData(aliasRdData)
  );

  // behavioural expectations from the requirements
  function automatic bit expHit();
    return rstN && reqValid && reqOp0 == 2'b11 && reqOp1 == 3'b011 &&
           reqCrn == 4'b1101 && reqCrm == 4'b0000 && reqOp2 == 3'b010;
  endfunction

  function automatic bit expTrap();
    bit gate;
    bit dirBit;
    if (!expHit()) return 0;
    gate = hypEnabled && fgtPresent && (!el3Present || monFgtEnable);
    dirBit = reqWrite ? wrTrapBit : rdTrapBit;
    if (curEl == 2'd0) return gate && !el0InHost && dirBit;  // R3
    if (curEl == 2'd1) return gate && dirBit;                // R4
    return 0;                                                // R5
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // reference state update
  always @(posedge clk) begin
    if (!rstN) model = 64'h0;
    else if (expHit() && reqWrite && !expTrap()) model = wrData;
    else if (aliasWrEn) model[31:0] = aliasWrData;
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN !== 1'bx && !done) begin
      bit h, t, rv;
      h = expHit();
      t = expTrap();
      rv = h && !reqWrite && !t;
      check("R2 hit", {63'h0, hit}, {63'h0, h});
      check("R3/R4/R5/R6 trap", {63'h0, trap}, {63'h0, t});
      check("R7 target", {62'h0, trapTargetEl}, t ? 64'd2 : 64'd0);
      check("R7 class", {58'h0, trapClass}, t ? 64'h18 : 64'd0);
      check("R8 rdValid", {63'h0, rdValid}, {63'h0, rv});
      check("R1 rdData", rdData, rv ? model : 64'h0);
      check("R9 alias", {32'h0, aliasRdData}, {32'h0, model[31:0]});
    end
  end

  task automatic idle();
    reqValid = 0; reqWrite = 0; aliasWrEn = 0;
    reqOp0 = 2'b11; reqOp1 = 3'b011; reqCrn = 4'b1101; reqCrm = 4'b0000; reqOp2 = 3'b010;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic acc(bit wr, logic [1:0] el, logic [63:0] d);
    reqValid = 1; reqWrite = wr; curEl = el; wrData = d;
    step();
    idle();
  endtask

  task automatic ctl(bit hyp, bit host, bit fgt, bit e3, bit mon, bit rt, bit wt);
    hypEnabled = hyp; el0InHost = host; fgtPresent = fgt;
    el3Present = e3; monFgtEnable = mon; rdTrapBit = rt; wrTrapBit = wt;
  endtask

  initial begin
    rstN = 0; idle(); curEl = 0; wrData = 0; aliasWrData = 0;
    ctl(0, 0, 0, 0, 0, 0, 0);
    repeat (3) step();
    reqValid = 1; reqWrite = 1; wrData = 64'hDEAD; step();  // R11: ignored in reset
    idle();
    rstN = 1;
    acc(0, 2'd3, 0);                                        // R11 reset value
    acc(1, 2'd3, 64'hA5A5_0123_4567_89AB);                  // R1
    acc(0, 2'd0, 0);
    acc(1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    acc(0, 2'd1, 0);
    // R2 misses on each field
    reqOp0 = 2'b10; acc(1, 2'd3, 64'h1);
    reqOp1 = 3'b010; acc(1, 2'd3, 64'h2);
    reqCrn = 4'b1100; acc(1, 2'd3, 64'h3);
    reqCrm = 4'b0001; acc(1, 2'd3, 64'h4);
    reqOp2 = 3'b011; acc(0, 2'd3, 0);
    acc(0, 2'd3, 0);
    // R3 all terms set: trap at level 0, reads and writes
    ctl(1, 0, 1, 1, 1, 1, 1);
    acc(0, 2'd0, 0);
    acc(1, 2'd0, 64'h1111);                                 // R8 write held
    acc(0, 2'd2, 0);
    // R3 each term cleared in turn
    ctl(1, 1, 1, 1, 1, 1, 1); acc(0, 2'd0, 0);              // host exempt
    ctl(0, 0, 1, 1, 1, 1, 1); acc(0, 2'd0, 0);
    ctl(1, 0, 0, 1, 1, 1, 1); acc(0, 2'd0, 0);
    ctl(1, 0, 1, 1, 0, 1, 1); acc(0, 2'd0, 0);
    ctl(1, 0, 1, 0, 0, 1, 1); acc(0, 2'd0, 0);              // no monitor: trap
    // R4 host term ignored at level 1
    ctl(1, 1, 1, 1, 1, 1, 1); acc(0, 2'd1, 0); acc(1, 2'd1, 64'h2222);
    // R5 upper levels with everything armed
    acc(1, 2'd2, 64'h3333_4444_5555_6666); acc(0, 2'd3, 0); acc(1, 2'd3, 64'h7777);
    // R6 direction-specific bits
    ctl(1, 0, 1, 1, 1, 0, 1); acc(0, 2'd0, 0); acc(1, 2'd0, 64'h8888); acc(0, 2'd1, 0);
    ctl(1, 0, 1, 1, 1, 1, 0); acc(1, 2'd0, 64'h9999_0000_AAAA); acc(0, 2'd0, 0);
    ctl(0, 0, 0, 0, 0, 0, 0);
    // R9 alias write keeps upper half
    acc(1, 2'd3, 64'hCAFE_F00D_0000_0001);
    aliasWrEn = 1; aliasWrData = 32'h1234_5678; step(); idle();
    acc(0, 2'd3, 0);
    // R10 same-cycle collision: 64-bit write wins
    aliasWrEn = 1; aliasWrData = 32'hBBBB_BBBB;
    reqValid = 1; reqWrite = 1; curEl = 2'd3; wrData = 64'h0102_0304_0506_0708;
    step(); idle();
    acc(0, 2'd3, 0);
    // alias write alongside a trapped write still applies
    ctl(1, 0, 1, 0, 0, 0, 1);
    aliasWrEn = 1; aliasWrData = 32'h0000_00EE;
    reqValid = 1; reqWrite = 1; curEl = 2'd1; wrData = 64'hFFFF;
    step(); idle();
    ctl(0, 0, 0, 0, 0, 0, 0);
    acc(0, 2'd3, 0);
    // R11 mid-run reset clears
    rstN = 0; step(); step(); rstN = 1;
    acc(0, 2'd3, 0);
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule